// File: doc/BRIEF.md
# Command-Driven Serial Register Interface

This block is the serial front door of a measurement converter. A host drives a serial clock, an active-low select and a data line. The block oversamples these three pins in a faster system clock. Every access opens with an 8-bit command byte, which names a register and says whether the host will write it or read it. A payload follows, and its length is fixed by the register that was addressed. The configuration registers drive a conversion sequencer. The sequencer hands back finished results through a strobe and a data word.

The serial output line does two jobs. While a payload is shifting out, it carries the payload. At any other time while the block is selected, it shows an active-low ready flag. A dedicated command byte places the block in a streaming mode. In that mode each 24-clock group returns the latest result with no new command. A second command byte leaves the mode, but only while a result is pending. A long run of ones on the data line forces a full return to defaults, which lets a host recover a lost frame.

Top module: `cmd_serial_regs`

## Requirements
- R1: While waiting for a command, a 1 sampled in the leading bit position is skipped without moving forward. The first 0 starts an 8-bit command, sent MSB first and sampled on rising serial-clock edges. In that command, bit 6 = 1 requests a read, bits 5:3 give the register address, and bit 2 requests streaming.
- R2: Address 0 reads back an 8-bit status byte {ready_n, 0, 0, 0, 1, channel[2:0]}, which is 0x88 after reset. Address 4 reads back the ID parameter, 8 bits.
- R3: Payload lengths are fixed per register. Addresses 1 and 2 take 16 bits, address 5 takes 8 bits, and addresses 3, 6 and 7 take 24 bits. Writes to address 3 (result) and address 4 (ID) change nothing. The mode, configuration and IO values appear on the sequencer outputs.
- R4: A read payload goes out MSB first. Each bit is presented after a falling edge and holds until the next rising edge.
- R5: `dout_oe` is 0 while the select pin is high. While the block is selected and not shifting out a payload, `dout` shows ready_n.
- R6: A `res_valid` strobe stores `res_data` and drives ready_n low. Completing a read of address 3 drives ready_n high.
- R7: 32 consecutive rising edges with the data line high return every register to its reset value and put the block back in the command-waiting state. The reset values are mode 0x000A, configuration 0x0710, IO 0x00, offset 0x800000 and full-scale FS_RST.
- R8: Command 0x5C starts streaming. In streaming, each group of 24 clocks returns the result register and sets ready_n high on completion.
- R9: Streaming ends only when the first 8 bits of a group equal 0x58 while ready_n is low. In any other case the group carries on and the block stays in streaming.
- R10: Writes to offset (address 6) and full-scale (address 7) take effect only while mode bits 15:13 are 010 or 011. At other times they are dropped.
- R11: Offset and full-scale each hold one copy per channel. The copy used is selected by configuration bits 1:0, and the value 3 maps to channel 2.
- R12: If the select pin rises partway through a transfer, the transfer is abandoned and any partial write is discarded. Outside streaming, the block goes back to waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low select from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data out, or the ready_n flag |
| dout_oe | output | 1 | Output enable for dout (0 = high impedance) |
| res_valid | input | 1 | One-cycle strobe marking a new result from the sequencer |
| res_data | input | 24 | Result word from the sequencer |
| mode_o | output | 16 | Mode register value |
| cfg_o | output | 16 | Configuration register value |
| io_o | output | 8 | IO register value |
| offset_o | output | 24 | Offset value for the selected channel |
| fscale_o | output | 24 | Full-scale value for the selected channel |

## Verification
The hardest situation to reach is the streaming exit decision. The exit byte must fall in the first eight clocks of a group. Whether it takes effect depends on ready_n at that instant, and ready_n is set by traffic on the sequencer side. The bench holds the select pin low for a whole streaming session and posts results partway through it. This lets it place the same 0x58 byte once with ready_n high, where it must be ignored, and once with ready_n low, where it must end streaming. After each attempt it reads the result register and the ID register to show which state the block is in.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int DW   = 24;
    localparam int MW   = 16;
    localparam int BW   = 8;
    localparam int AW   = 3;
    localparam int CNTW = 5;

    localparam logic [7:0] CMD_STREAM_ON  = 8'h5C;
    localparam logic [7:0] CMD_STREAM_OFF = 8'h58;

    localparam logic [2:0] MD_IDLE = 3'b010;
    localparam logic [2:0] MD_PDN  = 3'b011;

    localparam logic [AW-1:0] A_STAT = 3'd0;
    localparam logic [AW-1:0] A_MODE = 3'd1;
    localparam logic [AW-1:0] A_CFG  = 3'd2;
    localparam logic [AW-1:0] A_RES  = 3'd3;
    localparam logic [AW-1:0] A_ID   = 3'd4;
    localparam logic [AW-1:0] A_IO   = 3'd5;
    localparam logic [AW-1:0] A_OFS  = 3'd6;
    localparam logic [AW-1:0] A_FSC  = 3'd7;

    typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_STREAM} st_e;

    function automatic logic [CNTW-1:0] reg_len(input logic [AW-1:0] a);
        case (a)
            A_MODE, A_CFG:        return CNTW'(MW);
            A_RES, A_OFS, A_FSC:  return CNTW'(DW);
            default:              return CNTW'(BW);
        endcase
    endfunction
endpackage

// File: rtl/csr_pin_sync.sv
module csr_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_pkg::*;
#(
    parameter int              NCH    = 3,
    parameter logic [BW-1:0]   ID_VAL = 8'h4B,
    parameter logic [DW-1:0]   FS_RST = 24'h500005
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_val,
    input  logic          rd_done,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    output logic          rdy_n,
    output logic [MW-1:0] mode_o,
    output logic [MW-1:0] cfg_o,
    output logic [BW-1:0] io_o,
    output logic [DW-1:0] offset_o,
    output logic [DW-1:0] fscale_o
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [MW-1:0]           mode;
        logic [MW-1:0]           cfg;
        logic [BW-1:0]           io;
        logic [DW-1:0]           res;
        logic                    rdy_n;
        logic [NCH-1:0][DW-1:0]  ofs;
        logic [NCH-1:0][DW-1:0]  fsc;
    } bank_t;

    localparam bank_t BANK_RST = '{
        mode:  16'h000A,
        cfg:   16'h0710,
        io:    '0,
        res:   '0,
        rdy_n: 1'b1,
        ofs:   {NCH{24'h800000}},
        fsc:   {NCH{FS_RST}}
    };

    bank_t d, q;
    logic [CHW-1:0] ch_raw, ch;
    logic           unlocked;

    always_comb begin
        ch_raw   = q.cfg[CHW-1:0];
        ch       = (int'(ch_raw) > NCH - 1) ? CHW'(NCH - 1) : ch_raw;
        unlocked = (q.mode[MW-1 -: 3] == MD_IDLE) || (q.mode[MW-1 -: 3] == MD_PDN);

        d = q;
        if (res_valid) begin
            d.res   = res_data;
            d.rdy_n = 1'b0;
        end else if (rd_done) begin
            d.rdy_n = 1'b1;
        end
        if (wr_en) begin
            case (wr_addr)
                A_MODE: d.mode = wr_data[MW-1:0];
                A_CFG:  d.cfg  = wr_data[MW-1:0];
                A_IO:   d.io   = wr_data[BW-1:0];
                A_OFS:  if (unlocked) d.ofs[ch] = wr_data;
                A_FSC:  if (unlocked) d.fsc[ch] = wr_data;
                default: ;
            endcase
        end
        if (soft_rst) d = BANK_RST;

        case (rd_addr)
            A_STAT:  rd_val = {{(DW-BW){1'b0}}, q.rdy_n, 3'b000, 1'b1, 3'(ch)};
            A_MODE:  rd_val = {{(DW-MW){1'b0}}, q.mode};
            A_CFG:   rd_val = {{(DW-MW){1'b0}}, q.cfg};
            A_RES:   rd_val = q.res;
            A_ID:    rd_val = {{(DW-BW){1'b0}}, ID_VAL};
            A_IO:    rd_val = {{(DW-BW){1'b0}}, q.io};
            A_OFS:   rd_val = q.ofs[ch];
            default: rd_val = q.fsc[ch];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= BANK_RST;
        else        q <= d;
    end

    assign rdy_n    = q.rdy_n;
    assign mode_o   = q.mode;
    assign cfg_o    = q.cfg;
    assign io_o     = q.io;
    assign offset_o = q.ofs[ch];
    assign fscale_o = q.fsc[ch];
endmodule

// File: rtl/cmd_serial_regs.sv
module cmd_serial_regs
    import csr_pkg::*;
#(
    parameter int            NCH         = 3,
    parameter logic [7:0]    ID_VAL      = 8'h4B,
    parameter logic [23:0]   FS_RST      = 24'h500005,
    parameter int            RESYNC_LEN  = 32,
    parameter int            SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        din,
    output logic        dout,
    output logic        dout_oe,
    input  logic        res_valid,
    input  logic [23:0] res_data,
    output logic [15:0] mode_o,
    output logic [15:0] cfg_o,
    output logic [7:0]  io_o,
    output logic [23:0] offset_o,
    output logic [23:0] fscale_o
);
    localparam int OW = $clog2(RESYNC_LEN + 1);

    typedef struct packed {
        st_e             st;
        logic [CNTW-1:0] cnt;
        logic [DW-1:0]   si;
        logic [DW-1:0]   so;
        logic            act;
        logic [AW-1:0]   addr;
        logic [OW-1:0]   ones;
        logic            sclk_p;
        logic            cs_p;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_CMD, cnt: '0, si: '0, so: '0, act: 1'b0,
        addr: '0, ones: '0, sclk_p: 1'b1, cs_p: 1'b1
    };

    ctl_t d, q;
    logic sclk_s, cs_s, din_s;
    logic rise, fall, cs_rise;
    logic wr_en, rd_done, soft_rst, rdy_n, act;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data, rd_val, rd_word;
    logic [CNTW-1:0] len;
    logic [7:0]      byte_in;

    csr_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({sclk, cs_n, din}),
        .sync_o({sclk_s, cs_s, din_s})
    );

    always_comb begin
        rise    = sclk_s & ~q.sclk_p & ~cs_s;
        fall    = ~sclk_s & q.sclk_p & ~cs_s;
        cs_rise = cs_s & ~q.cs_p;
        len     = reg_len(q.addr);
        byte_in = {q.si[6:0], din_s};
        wr_data = {q.si[DW-2:0], din_s};
        rd_word = rd_val << (DW - int'(len));

        d        = q;
        wr_en    = 1'b0;
        rd_done  = 1'b0;
        soft_rst = 1'b0;

        if (cs_rise) begin
            d.cnt  = '0;
            d.act  = 1'b0;
            d.si   = '0;
            d.ones = '0;
            if (q.st != ST_STREAM) d.st = ST_CMD;
        end else begin
            if (fall && (q.st == ST_RD || q.st == ST_STREAM)) begin
                if (!q.act) begin
                    d.so  = rd_word;
                    d.act = 1'b1;
                end else begin
                    d.so  = q.so << 1;
                end
            end
            if (rise) begin
                d.ones = din_s ? q.ones + 1'b1 : '0;
                d.si   = wr_data;
                d.cnt  = q.cnt + 1'b1;
                case (q.st)
                    ST_CMD: begin
                        if (q.cnt == '0 && din_s) begin
                            d.cnt = '0;
                        end else if (q.cnt == CNTW'(7)) begin
                            d.cnt  = '0;
                            d.si   = '0;
                            d.addr = byte_in[5:3];
                            d.act  = 1'b0;
                            if (byte_in == CMD_STREAM_ON)  d.st = ST_STREAM;
                            else if (byte_in[6])           d.st = ST_RD;
                            else if (byte_in[5:3] != '0)   d.st = ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (q.cnt == len - 1'b1) begin
                            wr_en = 1'b1;
                            d.st  = ST_CMD;
                            d.cnt = '0;
                        end
                    end
                    ST_RD: begin
                        if (q.cnt == len - 1'b1) begin
                            rd_done = (q.addr == A_RES);
                            d.st    = ST_CMD;
                            d.cnt   = '0;
                            d.act   = 1'b0;
                        end
                    end
                    default: begin
                        if (q.cnt == CNTW'(7) && byte_in == CMD_STREAM_OFF && !rdy_n) begin
                            d.st  = ST_CMD;
                            d.cnt = '0;
                            d.act = 1'b0;
                            d.si  = '0;
                        end else if (q.cnt == CNTW'(DW - 1)) begin
                            rd_done = 1'b1;
                            d.cnt   = '0;
                            d.act   = 1'b0;
                            d.si    = '0;
                        end
                    end
                endcase
                if (d.ones == OW'(RESYNC_LEN)) begin
                    soft_rst = 1'b1;
                    wr_en    = 1'b0;
                    rd_done  = 1'b0;
                    d        = CTL_RST;
                end
            end
        end
        d.sclk_p = sclk_s;
        d.cs_p   = cs_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign wr_addr = q.addr;
    assign act     = q.act;
    assign dout    = q.act ? q.so[DW-1] : rdy_n;
    assign dout_oe = ~cs_s;

    csr_bank #(.NCH(NCH), .ID_VAL(ID_VAL), .FS_RST(FS_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(q.addr), .rd_val(rd_val), .rd_done(rd_done),
        .res_valid(res_valid), .res_data(res_data), .rdy_n(rdy_n),
        .mode_o(mode_o), .cfg_o(cfg_o), .io_o(io_o),
        .offset_o(offset_o), .fscale_o(fscale_o)
    );
endmodule

// File: rtl/csr_chk.sv
module csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        soft_rst,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic        rd_done,
    input logic        res_valid,
    input logic        rdy_n,
    input logic        act,
    input logic [15:0] mode_o,
    input logic [15:0] cfg_o,
    input logic [23:0] offset_o
);
    logic unlk;
    assign unlk = (mode_o[15:13] == 3'b010) || (mode_o[15:13] == 3'b011);

    AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_o == 16'h000A && cfg_o == 16'h0710)); // R7

    AST_OFFSET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd6 && !unlk) |=> $stable(offset_o)); // R10

    AST_RESULT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !rdy_n); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !res_valid && !soft_rst) |=> rdy_n); // R6

    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |-> !wr_en); // R12

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> !act); // R12

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_done, soft_rst})); // R3
endmodule

bind cmd_serial_regs csr_chk u_chk (.*);

// File: tb/sim_cmd_serial_regs.sv
`timescale 1ns/1ps
module sim_cmd_serial_regs;
    localparam int          HALF = 6;
    localparam logic [7:0]  IDV  = 8'h4B;
    localparam logic [23:0] FSR  = 24'h500005;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
    logic res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic dout, dout_oe;
    logic [15:0] mode_o, cfg_o;
    logic [7:0]  io_o;
    logic [23:0] offset_o, fscale_o;

    int errors = 0, checks = 0;

    logic [15:0] m_mode, m_cfg;
    logic [7:0]  m_io;
    logic [23:0] m_res;
    logic        m_rdyn;
    logic [23:0] m_ofs [3];
    logic [23:0] m_fsc [3];

    always #2.5 clk = ~clk;

    cmd_serial_regs u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .res_valid(res_valid), .res_data(res_data),
        .mode_o(mode_o), .cfg_o(cfg_o), .io_o(io_o),
        .offset_o(offset_o), .fscale_o(fscale_o)
    );

    task automatic m_reset();
        m_mode = 16'h000A; m_cfg = 16'h0710; m_io = 8'h00; m_res = '0; m_rdyn = 1'b1;
        for (int i = 0; i < 3; i++) begin m_ofs[i] = 24'h800000; m_fsc[i] = FSR; end
    endtask

    function automatic int m_ch();
        return (m_cfg[1:0] == 2'd3) ? 2 : int'(m_cfg[1:0]);
    endfunction

    function automatic int b_len(input logic [2:0] a);
        return (a == 3'd1 || a == 3'd2) ? 16 : (a == 3'd3 || a == 3'd6 || a == 3'd7) ? 24 : 8;
    endfunction

    function automatic logic [23:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_rdyn, 3'b000, 1'b1, 3'(m_ch())};
            3'd1: return {8'h0, m_mode};
            3'd2: return {8'h0, m_cfg};
            3'd3: return m_res;
            3'd4: return {16'h0, IDV};
            3'd5: return {16'h0, m_io};
            3'd6: return m_ofs[m_ch()];
            default: return m_fsc[m_ch()];
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic o);
        @(negedge clk); sclk = 1'b0; din = b;
        repeat (HALF) @(negedge clk);
        o = dout; sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] v, input int n, output logic [31:0] got);
        logic o;
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sbit(v[i], o);
            got = {got[30:0], o};
        end
        din = 1'b0;
    endtask

    task automatic sel();
        @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
        logic [31:0] g;
        logic ul;
        sel(); xfer({24'h0, 2'b00, a, 3'b000}, 8, g); xfer({8'h0, v}, b_len(a), g); desel();
        ul = (m_mode[15:13] == 3'b010) || (m_mode[15:13] == 3'b011);
        case (a)
            3'd1: m_mode = v[15:0];
            3'd2: m_cfg  = v[15:0];
            3'd5: m_io   = v[7:0];
            3'd6: if (ul) m_ofs[m_ch()] = v;
            3'd7: if (ul) m_fsc[m_ch()] = v;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
        logic [31:0] g;
        sel(); xfer({24'h0, 2'b01, a, 3'b000}, 8, g); xfer(32'h0, b_len(a), g); desel();
        v = g[23:0];
        if (a == 3'd3) m_rdyn = 1'b1;
    endtask

    task automatic post(input logic [23:0] v);
        @(negedge clk); res_valid = 1'b1; res_data = v;
        @(negedge clk); res_valid = 1'b0;
        repeat (4) @(negedge clk);
        m_res = v; m_rdyn = 1'b0;
    endtask

    task automatic check_outs(input string req);
        chk({req, " mode_o"},   {16'h0, mode_o}, {16'h0, m_mode});
        chk({req, " cfg_o"},    {16'h0, cfg_o},  {16'h0, m_cfg});
        chk({req, " io_o"},     {24'h0, io_o},   {24'h0, m_io});
        chk({req, " offset_o"}, {8'h0, offset_o}, {8'h0, m_ofs[m_ch()]});
        chk({req, " fscale_o"}, {8'h0, fscale_o}, {8'h0, m_fsc[m_ch()]});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] g;
        logic [23:0] v;
        logic [2:0]  wa_list [5];
        logic [2:0]  ra_list [7];
        wa_list = '{3'd1, 3'd2, 3'd5, 3'd6, 3'd7};
        ra_list = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
        void'($urandom(32'd2024));
        m_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        chk("R5 deselected hi-z", {31'h0, dout_oe}, 32'h0);
        check_outs("R7 reset");
        rd_reg(3'd0, v); chk("R2 status reset", {8'h0, v}, 32'h88);
        rd_reg(3'd4, v); chk("R2 id", {8'h0, v}, {24'h0, IDV});

        // ready flag on the pin and result read
        sel();
        chk("R5 selected oe", {31'h0, dout_oe}, 32'h1);
        chk("R5 idle shows ready_n high", {31'h0, dout}, 32'h1);
        post(24'hC3A55A);
        chk("R6 result pending ready_n low", {31'h0, dout}, 32'h0);
        xfer(32'h58, 8, g); xfer(32'h0, 24, g);
        m_rdyn = 1'b1;
        chk("R4 R6 result read", g, 32'hC3A55A);
        repeat (4) @(negedge clk);
        chk("R6 ready_n high after read", {31'h0, dout}, 32'h1);
        desel();
        chk("R5 hi-z after deselect", {31'h0, dout_oe}, 32'h0);

        // leading ones before command
        sel(); xfer(32'h7, 3, g); xfer(32'h60, 8, g); xfer(32'h0, 8, g); desel();
        chk("R1 leading ones skipped", g, {24'h0, IDV});

        // read-only addresses ignore writes
        wr_reg(3'd4, 24'h00); rd_reg(3'd4, v);
        chk("R3 id write ignored", {8'h0, v}, {24'h0, IDV});
        wr_reg(3'd3, 24'h123456); rd_reg(3'd3, v);
        chk("R3 result write ignored", {8'h0, v}, {8'h0, m_res});

        // lock check directed: continuous mode blocks offset writes
        wr_reg(3'd1, 24'h0000_0A); wr_reg(3'd6, 24'h0BCDEF); rd_reg(3'd6, v);
        chk("R10 offset locked", {8'h0, v}, 32'h800000);
        wr_reg(3'd1, 24'h00_4000); wr_reg(3'd2, 24'h00_0003); wr_reg(3'd6, 24'h0BCDEF);
        rd_reg(3'd6, v); chk("R11 channel 3 maps to 2", {8'h0, v}, {8'h0, m_ofs[2]});
        check_outs("R11 banked");

        // random register traffic
        for (int it = 0; it < 40; it++) begin
            logic [2:0]  wa, ra;
            logic [23:0] wv;
            wa = wa_list[$urandom_range(0, 4)];
            wv = 24'($urandom);
            if (wa == 3'd1) wv[15:13] = 3'($urandom_range(0, 3));
            wr_reg(wa, wv);
            check_outs("R3 R10 R11 random");
            ra = ra_list[$urandom_range(0, 6)];
            rd_reg(ra, v);
            chk("R2 R4 R10 random readback", {8'h0, v}, {8'h0, m_read(ra)});
        end

        // abort on select rise
        wr_reg(3'd1, 24'h0000AB);
        sel(); xfer(32'h08, 8, g); xfer(32'hFF, 8, g); desel();
        rd_reg(3'd1, v);
        chk("R12 partial write dropped", {8'h0, v}, 32'h00AB);
        rd_reg(3'd4, v);
        chk("R12 back to command", {8'h0, v}, {24'h0, IDV});

        // streaming mode
        post(24'h111111);
        sel(); xfer(32'h5C, 8, g);
        chk("R8 R5 ready_n low after stream cmd", {31'h0, dout}, 32'h0);
        xfer(32'h0, 24, g); m_rdyn = 1'b1;
        chk("R8 stream group 1", g, 32'h111111);
        repeat (4) @(negedge clk);
        chk("R8 ready_n high after group", {31'h0, dout}, 32'h1);
        post(24'h222222);
        xfer(32'h0, 24, g); m_rdyn = 1'b1;
        chk("R8 stream group 2", g, 32'h222222);
        xfer(32'h58, 8, g); xfer(32'h0, 16, g);
        post(24'h333333);
        xfer(32'h0, 24, g); m_rdyn = 1'b1;
        chk("R9 exit ignored while ready high", g, 32'h333333);
        post(24'h444444);
        xfer(32'h58, 8, g);
        desel();
        rd_reg(3'd4, v);
        chk("R9 exit while ready low", {8'h0, v}, {24'h0, IDV});
        rd_reg(3'd0, v);
        chk("R9 status after exit", {8'h0, v}, {8'h0, m_read(3'd0)});

        // resynchronisation run
        wr_reg(3'd1, 24'h002000); wr_reg(3'd5, 24'h00005A); wr_reg(3'd2, 24'h000001);
        sel(); xfer(32'hFFFFFFFF, 32, g); desel();
        m_reset();
        check_outs("R7 resync defaults");
        rd_reg(3'd0, v);
        chk("R7 status after resync", {8'h0, v}, 32'h88);

        summary();
    end
endmodule